// File: doc/BRIEF.md
# Display Pixel Format Packer

This block sits between a pixel fetch stream and a panel link. Each incoming pixel word is read in one of three memory layouts. It is split into red, green and blue, and each component is cut down to the bit depth that the attached panel takes. The three components are then packed into a 24-bit output word, with red or blue in the top field. An optional 4x4 ordered dither can be added before the bits are dropped, so that colour banding is smoothed on 18-bit and 16-bit panels.

A small register file sits next to the datapath and holds the settings for the fetch engine: a format word, the window size, a start address, a line stride and an origin that always reads as zero. The window size also defines the raster position that the dither pattern uses. A write to the format word or to the window size restarts that position at the top-left pixel. Both streams use valid/ready handshakes, and an accepted pixel appears on the output one cycle later.

Top module: `pix_pack_top`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the registers at offsets 0x0, 0x4, 0x8 and 0xC read as zero.
- R2: Registers are written when reg_we is high and read combinationally at reg_addr. The format word is at 0x0, and only bits [6:0] are stored; bits [31:7] read as zero. The window is at 0x4, with height in [31:16] and width in [15:0]. The start address is at 0x8 and the line stride in bytes is at 0xC. The window, start address and stride are also driven on fetch_width, fetch_height, fetch_base and fetch_stride.
- R3: The origin register at 0x10 always reads zero, and a write to it has no effect. Any other offset also reads zero.
- R4: The input layout is set by format bits [1:0]. 0 selects 16-bit 5-6-5 with R in [15:11], G in [10:5] and B in [4:0]; each field is widened to 8 bits by repeating its top bits. 1 selects 24-bit with R in [23:16], G in [15:8] and B in [7:0]. 2 and 3 select 32-bit with the same byte positions; bits [31:24] are ignored.
- R5: Format bits [3:2] set the component depths for G/B/R. 0 and 3 select 8/8/8, 1 selects 6/6/6 and 2 selects 6/5/5. Without dither, each component keeps its most significant bits.
- R6: Format bit 4 selects the pack order. When it is 0, the word is {R,G,B} with B at the LSB end. When it is 1, the word is {B,G,R} with R at the LSB end.
- R7: Format bit 6 set places the packed fields at bit 0, and the unused high bits are zero. When bit 6 is clear, the fields are shifted up so that the top field ends at bit 23, and the low bits are zero.
- R8: Format bit 5 enables dither. A threshold T from the 4x4 matrix rows {0,8,2,10},{12,4,14,6},{3,11,1,9},{15,7,13,5} is used, with the row taken from line y mod 4 and the column from pixel x mod 4. For a component that drops d bits, T>>(4-d) is added to it before truncation. The sum saturates at 255. An 8-bit component is not changed by dither.
- R9: An accepted pixel gives out_valid one cycle later. While out_ready is low, the output word is held unchanged. in_ready is high whenever the output stage is empty or is being drained.
- R10: The pixel position advances on each accepted pixel. x wraps at the window width and then y advances; y wraps at the window height. A write to 0x0 or 0x4 returns the position to (0,0). A pixel accepted in the same cycle as such a write is packed with the previous format and the previous position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr |
| in_valid | input | 1 | Source pixel valid |
| in_ready | output | 1 | Source pixel accepted when high with in_valid |
| in_pixel | input | 32 | Source pixel word |
| out_valid | output | 1 | Packed word valid |
| out_ready | input | 1 | Downstream accepts the packed word |
| out_word | output | 24 | Packed panel word |
| fetch_base | output | 32 | Fetch start address |
| fetch_stride | output | 32 | Line stride in bytes |
| fetch_width | output | 16 | Window width in pixels |
| fetch_height | output | 16 | Window height in lines |

## Verification
Two events can land on the same clock edge: a register write that changes the format word, and the acceptance of a pixel. Both also move the raster position that the dither uses. The bench forces the output to stay ready so that the pixel handshake is certain to complete, and drives the write and the pixel in the same cycle. It expects that pixel to be packed with the old format and the old position, and expects the next pixel to use the new format at position (0,0). Under output backpressure, the scoreboard also checks that frames wrap and that the dither positions follow the window size.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;

    localparam int NCOMP = 3;

    typedef enum logic [1:0] {
        FMT_565  = 2'd0,
        FMT_888  = 2'd1,
        FMT_X888 = 2'd2,
        FMT_X888_ALT = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        DEP_888 = 2'd0,
        DEP_666 = 2'd1,
        DEP_655 = 2'd2,
        DEP_888_ALT = 2'd3
    } depth_e;

    typedef struct packed {
        logic   align_lsb;
        logic   dither_en;
        logic   bgr;
        depth_e depth;
        fmt_e   fmt;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    // Bits dropped for component idx (0 = green, 1 = blue, 2 = red).
    function automatic logic [1:0] drop_bits(depth_e d, int idx);
        case (d)
            DEP_666: return 2'd2;
            DEP_655: return (idx == 0) ? 2'd2 : 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    // 4x4 ordered threshold, built from interleaved position bits.
    function automatic logic [3:0] bayer(logic [1:0] x, logic [1:0] y);
        return {x[0] ^ y[0], y[0], x[1] ^ y[1], y[1]};
    endfunction

endpackage

// File: rtl/pix_pack_regs.sv
module pix_pack_regs
    import pix_pack_pkg::*;
#(
    parameter int AW    = 5,
    parameter int DW    = 32,
    parameter int DIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output cfg_t             cfg_o,
    output logic [DIM_W-1:0] win_w,
    output logic [DIM_W-1:0] win_h,
    output logic [DW-1:0]    base_o,
    output logic [DW-1:0]    stride_o,
    output logic             pos_clear
);
    localparam logic [AW-1:0] OFS_CFG    = AW'(5'h00);
    localparam logic [AW-1:0] OFS_WIN    = AW'(5'h04);
    localparam logic [AW-1:0] OFS_BASE   = AW'(5'h08);
    localparam logic [AW-1:0] OFS_STRIDE = AW'(5'h0C);

    typedef struct packed {
        cfg_t             cfg;
        logic [DIM_W-1:0] w;
        logic [DIM_W-1:0] h;
        logic [DW-1:0]    base;
        logic [DW-1:0]    stride;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                OFS_CFG:    r_d.cfg    = cfg_t'(wdata[CFG_W-1:0]);
                OFS_WIN: begin
                    r_d.w = wdata[DIM_W-1:0];
                    r_d.h = wdata[2*DIM_W-1:DIM_W];
                end
                OFS_BASE:   r_d.base   = wdata;
                OFS_STRIDE: r_d.stride = wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            OFS_CFG:    rdata = DW'(r_q.cfg);
            OFS_WIN:    rdata = DW'({r_q.h, r_q.w});
            OFS_BASE:   rdata = r_q.base;
            OFS_STRIDE: rdata = r_q.stride;
            default:    rdata = '0;
        endcase
    end

    assign cfg_o     = r_q.cfg;
    assign win_w     = r_q.w;
    assign win_h     = r_q.h;
    assign base_o    = r_q.base;
    assign stride_o  = r_q.stride;
    assign pos_clear = we && (addr == OFS_CFG || addr == OFS_WIN);

endmodule

// File: rtl/pix_pack_unpack.sv
module pix_pack_unpack
    import pix_pack_pkg::*;
#(
    parameter int PIX_W = 32,
    parameter int CW    = 8
) (
    input  fmt_e             fmt,
    input  logic [PIX_W-1:0] pix,
    output logic [CW-1:0]    r,
    output logic [CW-1:0]    g,
    output logic [CW-1:0]    b
);
    logic unused_alpha;
    assign unused_alpha = ^pix[PIX_W-1:3*CW];

    always_comb begin
        case (fmt)
            FMT_565: begin
                r = {pix[15:11], pix[15:13]};
                g = {pix[10:5],  pix[10:9]};
                b = {pix[4:0],   pix[4:2]};
            end
            default: begin
                r = pix[3*CW-1:2*CW];
                g = pix[2*CW-1:CW];
                b = pix[CW-1:0];
            end
        endcase
    end
endmodule

// File: rtl/pix_pack_reduce.sv
module pix_pack_reduce #(
    parameter int CW  = 8,
    parameter int THW = 4
) (
    input  logic [CW-1:0]  comp,
    input  logic [1:0]     drop,
    input  logic [THW-1:0] thr,
    input  logic           dither_en,
    output logic [CW-1:0]  comp_o
);
    localparam logic [CW:0] SAT = {1'b0, {CW{1'b1}}};

    logic [THW-1:0] add;
    logic [CW:0]    sum;
    logic [CW-1:0]  sat;

    always_comb begin
        add = '0;
        if (dither_en) begin
            case (drop)
                2'd2:    add = thr >> 2;
                2'd3:    add = thr >> 1;
                default: add = '0;
            endcase
        end
        sum    = {1'b0, comp} + (CW+1)'(add);
        sat    = (sum > SAT) ? SAT[CW-1:0] : sum[CW-1:0];
        comp_o = sat >> drop;
    end
endmodule

// File: rtl/pix_pack_top.sv
module pix_pack_top
    import pix_pack_pkg::*;
#(
    parameter int PIX_W  = 32,
    parameter int OUT_W  = 24,
    parameter int DIM_W  = 16,
    parameter int REG_AW = 5,
    parameter int REG_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pixel,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_word,
    output logic [REG_DW-1:0] fetch_base,
    output logic [REG_DW-1:0] fetch_stride,
    output logic [DIM_W-1:0]  fetch_width,
    output logic [DIM_W-1:0]  fetch_height
);
    localparam int CW  = OUT_W / NCOMP;
    localparam int SHW = $clog2(OUT_W + 1);

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] word;
        logic [DIM_W-1:0] x;
        logic [DIM_W-1:0] y;
    } state_t;

    state_t st_d, st_q;

    cfg_t             cfg_word;
    logic             pos_clear;
    logic [CW-1:0]    comp_in  [NCOMP];
    logic [CW-1:0]    comp_out [NCOMP];
    logic [1:0]       drop     [NCOMP];
    logic [3:0]       thr;
    logic             accept;

    pix_pack_regs #(.AW(REG_AW), .DW(REG_DW), .DIM_W(DIM_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cfg_o(cfg_word),
        .win_w(fetch_width), .win_h(fetch_height), .base_o(fetch_base),
        .stride_o(fetch_stride), .pos_clear(pos_clear)
    );

    // component slots: 0 green, 1 blue, 2 red
    pix_pack_unpack #(.PIX_W(PIX_W), .CW(CW)) unpack_i (
        .fmt(cfg_word.fmt), .pix(in_pixel),
        .r(comp_in[2]), .g(comp_in[0]), .b(comp_in[1])
    );

    assign thr = bayer(st_q.x[1:0], st_q.y[1:0]);

    for (genvar gi = 0; gi < NCOMP; gi++) begin : g_comp
        assign drop[gi] = drop_bits(cfg_word.depth, gi);
        pix_pack_reduce #(.CW(CW), .THW(4)) reduce_i (
            .comp(comp_in[gi]), .drop(drop[gi]), .thr(thr),
            .dither_en(cfg_word.dither_en), .comp_o(comp_out[gi])
        );
    end

    assign in_ready = !st_q.vld || out_ready;
    assign accept   = in_valid && in_ready;

    logic [SHW-1:0]   wg, wb, wr, wtot;
    logic [OUT_W-1:0] packed_w;

    always_comb begin
        st_d = st_q;
        wg   = SHW'(CW) - SHW'(drop[0]);
        wb   = SHW'(CW) - SHW'(drop[1]);
        wr   = SHW'(CW) - SHW'(drop[2]);
        wtot = wg + wb + wr;

        if (cfg_word.bgr)
            packed_w = (OUT_W'(comp_out[1]) << (wg + wr)) |
                       (OUT_W'(comp_out[0]) << wr) | OUT_W'(comp_out[2]);
        else
            packed_w = (OUT_W'(comp_out[2]) << (wg + wb)) |
                       (OUT_W'(comp_out[0]) << wb) | OUT_W'(comp_out[1]);
        if (!cfg_word.align_lsb)
            packed_w = packed_w << (SHW'(OUT_W) - wtot);

        if (accept) begin
            st_d.vld  = 1'b1;
            st_d.word = packed_w;
            if ({1'b0, st_q.x} + (DIM_W+1)'(1) >= {1'b0, fetch_width}) begin
                st_d.x = '0;
                if ({1'b0, st_q.y} + (DIM_W+1)'(1) >= {1'b0, fetch_height})
                    st_d.y = '0;
                else
                    st_d.y = st_q.y + 1'b1;
            end else begin
                st_d.x = st_q.x + 1'b1;
            end
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end

        if (pos_clear) begin
            st_d.x = '0;
            st_d.y = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_word  = st_q.word;

endmodule

// File: rtl/pix_pack_chk.sv
module pix_pack_chk #(
    parameter int OUT_W  = 24,
    parameter int REG_AW = 5,
    parameter int REG_DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OUT_W-1:0]  out_word,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_rdata,
    input logic [6:0]        cfg_bits
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word));

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid);

    assert_origin_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == REG_AW'(5'h10) |-> reg_rdata == '0);

    assert_lsb_655_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && cfg_bits[6] && cfg_bits[3:2] == 2'd2
        |=> out_word[OUT_W-1:16] == '0);

    assert_lsb_666_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && cfg_bits[6] && cfg_bits[3:2] == 2'd1
        |=> out_word[OUT_W-1:18] == '0);
endmodule

bind pix_pack_top pix_pack_chk #(.OUT_W(OUT_W), .REG_AW(REG_AW), .REG_DW(REG_DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .cfg_bits(cfg_word)
);

// File: tb/pix_pack_top_tb_top.sv
module pix_pack_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_pixel = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_word;
    logic [31:0] fetch_base, fetch_stride;
    logic [15:0] fetch_width, fetch_height;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_pack_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_pixel(in_pixel), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word), .fetch_base(fetch_base),
        .fetch_stride(fetch_stride), .fetch_width(fetch_width),
        .fetch_height(fetch_height)
    );

    int total = 0;
    int bad = 0;
    logic [23:0] exp_q[$];
    string       req_q[$];
    logic [6:0]  cur_cfg = '0;
    int pos_x = 0, pos_y = 0, win_w = 0, win_h = 0;
    bit rdy_force = 1'b0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1ACE_B00C;
    int cyc = 0;
    int bt[16] = '{0, 8, 2, 10, 12, 4, 14, 6, 3, 11, 1, 9, 15, 7, 13, 5};

    task automatic check(string req, logic [31:0] act, logic [31:0] expv, string what);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] red8(logic [7:0] c, int drop, int t, bit den);
        int s = c;
        if (den && drop > 0) s += t >> (4 - drop);
        if (s > 255) s = 255;
        return 8'(s >> drop);
    endfunction

    function automatic logic [23:0] model(logic [6:0] cfg, logic [31:0] p, int x, int y);
        logic [7:0] r, g, b;
        int dg, db, dr, wg, wb, wr, t;
        longint w;
        if (cfg[1:0] == 2'd0) begin
            r = {p[15:11], p[15:13]};
            g = {p[10:5], p[10:9]};
            b = {p[4:0], p[4:2]};
        end else begin
            r = p[23:16]; g = p[15:8]; b = p[7:0];
        end
        dg = 0; db = 0; dr = 0;
        if (cfg[3:2] == 2'd1) begin dg = 2; db = 2; dr = 2; end
        if (cfg[3:2] == 2'd2) begin dg = 2; db = 3; dr = 3; end
        t = bt[(y % 4) * 4 + (x % 4)];
        r = red8(r, dr, t, cfg[5]);
        g = red8(g, dg, t, cfg[5]);
        b = red8(b, db, t, cfg[5]);
        wg = 8 - dg; wb = 8 - db; wr = 8 - dr;
        if (cfg[4]) w = (longint'(b) << (wg + wr)) | (longint'(g) << wr) | longint'(r);
        else        w = (longint'(r) << (wg + wb)) | (longint'(g) << wb) | longint'(b);
        if (!cfg[6]) w = w << (24 - (wg + wb + wr));
        return 24'(w);
    endfunction

    function automatic logic [31:0] next_rand(logic [31:0] s);
        logic [31:0] v = s;
        v ^= v << 13; v ^= v >> 17; v ^= v << 5;
        return v;
    endfunction

    function automatic void model_write(logic [4:0] a, logic [31:0] d);
        if (a == 5'h00) begin cur_cfg = d[6:0]; pos_x = 0; pos_y = 0; end
        if (a == 5'h04) begin win_w = d[15:0]; win_h = d[31:16]; pos_x = 0; pos_y = 0; end
    endfunction

    function automatic void advance();
        pos_x++;
        if (pos_x >= win_w) begin
            pos_x = 0;
            pos_y++;
            if (pos_y >= win_h) pos_y = 0;
        end
    endfunction

    // all driver tasks start and end one time unit after a rising edge
    task automatic reg_write(logic [4:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic reg_check(logic [4:0] a, logic [31:0] e, string req);
        reg_addr = a;
        @(negedge clk);
        check(req, reg_rdata, e, $sformatf("reg 0x%0h", a));
        @(posedge clk); #1;
    endtask

    task automatic send_pix(logic [31:0] p, string req, bit wr, logic [4:0] a, logic [31:0] d);
        in_valid = 1'b1; in_pixel = p;
        if (wr) begin reg_we = 1'b1; reg_addr = a; reg_wdata = d; end
        forever begin
            @(negedge clk);
            if (in_ready) break;
            @(posedge clk); #1;
        end
        exp_q.push_back(model(cur_cfg, p, pos_x, pos_y));
        req_q.push_back(req);
        advance();
        if (wr) model_write(a, d);
        @(posedge clk); #1;
        in_valid = 1'b0; reg_we = 1'b0;
    endtask

    task automatic burst(int n, string req);
        for (int i = 0; i < n; i++) begin
            seed = next_rand(seed);
            send_pix(seed, req, 1'b0, '0, '0);
        end
    endtask

    // output ready pattern with backpressure unless forced
    always begin
        @(posedge clk); #1;
        cyc++;
        out_ready = rdy_force || (cyc % 3 != 1);
    end

    // scoreboard monitor
    bit         stalled = 1'b0;
    logic [23:0] held;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stalled) begin
                check("R9", {7'b0, out_valid, out_word}, {7'b0, 1'b1, held}, "held under stall");
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R9 unexpected word actual=%h expected=none", out_word);
                end else begin
                    logic [23:0] e;
                    string rq;
                    e = exp_q.pop_front();
                    rq = req_q.pop_front();
                    check(rq, {8'b0, out_word}, {8'b0, e}, "packed word");
                end
            end
            stalled = out_valid && !out_ready;
            held = out_word;
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", {31'b0, out_valid}, 32'd0, "out_valid after reset");
        check("R1", {31'b0, in_ready}, 32'd1, "in_ready after reset");
        @(posedge clk); #1;
        reg_check(5'h00, 32'h0, "R1");
        reg_check(5'h04, 32'h0, "R1");
        reg_check(5'h08, 32'h0, "R1");
        reg_check(5'h0C, 32'h0, "R1");

        // register file
        reg_write(5'h04, 32'h0003_0005);
        reg_check(5'h04, 32'h0003_0005, "R2");
        check("R2", {16'b0, fetch_height}, 32'd3, "fetch_height");
        check("R2", {16'b0, fetch_width}, 32'd5, "fetch_width");
        reg_write(5'h08, 32'h8000_1000);
        reg_check(5'h08, 32'h8000_1000, "R2");
        check("R2", fetch_base, 32'h8000_1000, "fetch_base");
        reg_write(5'h0C, 32'h0000_1400);
        reg_check(5'h0C, 32'h0000_1400, "R2");
        check("R2", fetch_stride, 32'h0000_1400, "fetch_stride");
        reg_write(5'h00, 32'hFFFF_FFFF);
        reg_check(5'h00, 32'h0000_007F, "R2");
        reg_write(5'h10, 32'h0000_1234);
        reg_check(5'h10, 32'h0, "R3");
        reg_check(5'h14, 32'h0, "R3");
        reg_check(5'h04, 32'h0003_0005, "R3");

        // 24-bit source, full depth, RGB, LSB aligned
        reg_write(5'h00, 32'h41);
        send_pix(32'hFF12_3456, "R4", 1'b0, '0, '0);
        burst(6, "R4");
        // 5-6-5 source into 6/5/5 output
        reg_write(5'h00, 32'h48);
        send_pix(32'h0000_F81F, "R5", 1'b0, '0, '0);
        burst(6, "R5");
        // 5-6-5 source into 8/8/8, widening check
        reg_write(5'h00, 32'h40);
        send_pix(32'h0000_07E0, "R4", 1'b0, '0, '0);
        burst(4, "R4");
        // 32-bit source, 6/6/6, BGR, dither, across frame wrap (R10)
        reg_write(5'h00, 32'h76);
        send_pix(32'hAAFF_FFFF, "R8", 1'b0, '0, '0);
        burst(19, "R10");
        // MSB aligned 6/6/6 with dither
        reg_write(5'h00, 32'h35);
        burst(8, "R7");
        // BGR 6/5/5 MSB aligned
        reg_write(5'h00, 32'h18);
        burst(6, "R6");
        // dither on 6/5/5 with saturation
        reg_write(5'h00, 32'h68);
        send_pix(32'h0000_FFFF, "R8", 1'b0, '0, '0);
        burst(8, "R8");

        // write in the same cycle as an accepted pixel
        rdy_force = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        burst(2, "R10");
        seed = next_rand(seed);
        send_pix(seed, "R10", 1'b1, 5'h00, 32'h6D);
        burst(5, "R10");
        send_pix(32'h1234_5678, "R10", 1'b1, 5'h04, 32'h0002_0002);
        burst(5, "R10");

        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R9", exp_q.size(), 32'd0, "all words delivered");
        done = 1'b1;
        finish_run();
    end
endmodule